// File: doc/BRIEF.md
# Parallel Programming Target Port

This block is the device side of a byte-wide parallel programming port for an on-chip program memory. A host drives a two-bit mode select, a byte-select line and an 8-bit data bus, then pulses a load strobe. Each rising edge of that strobe captures the bus as a command byte, the low address byte or one half of a 16-bit data word, depending on the mode. A second strobe, the latch strobe, stores the assembled word in a page buffer at the in-page offset of the loaded address. An active-low write pulse then starts the loaded command. A timed operation runs while the ready output is held low.

Two commands are understood. Chip erase sets the whole flash to ones, then sets the lock bits to ones. It also sets the EEPROM to ones unless a save fuse is programmed. Page write copies the page buffer into the flash page chosen by the upper address bits. All strobes are synchronized to the system clock and edge-detected. The flash, EEPROM, lock bits and fuse bits are exposed as registered read ports so the programming result is observable.

Top module: `pprog_target`

## Requirements
- R1: After reset, ready is 1 and lock_bits equals LOCK_INIT. fuse_bits equals FUSE_INIT, and EEPROM byte i reads i XOR 0xA5.
- R2: A rising load_stb edge with mode_sel=2'b10 stores data_in as the command. 0x80 is chip erase and 0x10 is page write. A write pulse under any other command has no effect: ready stays 1 and the flash is unchanged.
- R3: A rising load_stb edge with mode_sel=2'b00 and byte_sel=0 loads the low address. With byte_sel=1 the address is left unchanged.
- R4: A rising load_stb edge with mode_sel=2'b01 loads the low data byte when byte_sel=0 and the high data byte when byte_sel=1. The word is {high, low}.
- R5: A rising latch_stb edge stores the current word into the page-buffer slot given by the low log2(PAGE_WORDS) address bits.
- R6: A falling wr_n edge under page write copies every page-buffer slot into flash. The target page is the one selected by the address bits above the in-page offset.
- R7: A falling wr_n edge under a known command drives ready low at the third clock edge. Ready then stays low for exactly BUSY_CYCLES cycles.
- R8: Chip erase sets every flash word to 0xFFFF and every lock bit to 1. It leaves fuse_bits unchanged.
- R9: Chip erase sets every EEPROM byte to 0xFF when fuse bit EESAVE_BIT is 1. When that bit is 0 it leaves the EEPROM unchanged.
- R10: Lock bits hold their value throughout the erase sweep. They change only at the clock edge where ready returns high.
- R11: Load, latch and write strobes seen while ready is low are ignored.
- R12: flash_rdata and ee_rdata present the addressed word one clock after the read address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Selects what a load edge captures (00 address, 01 data, 10 command) |
| byte_sel | input | 1 | Low/high byte select |
| data_in | input | 8 | Shared programming data bus |
| load_stb | input | 1 | Load strobe, captures on rising edge |
| latch_stb | input | 1 | Page-buffer latch strobe, rising edge |
| wr_n | input | 1 | Active-low write pulse that starts the command |
| ready | output | 1 | 1 when idle, 0 while an operation runs |
| flash_raddr | input | ADDR_W | Flash read address |
| flash_rdata | output | 16 | Flash read data, one cycle latency |
| ee_raddr | input | $clog2(EE_DEPTH) | EEPROM read address |
| ee_rdata | output | 8 | EEPROM read data, one cycle latency |
| lock_bits | output | LOCK_W | Lock bit register |
| fuse_bits | output | 8 | Fuse bit register |

## Verification
A wrong command or address register shows up as flash words landing in the wrong page, or as ones where data belongs. This is visible on the read port once ready returns high. A busy counter that is off by one changes the measured low time of ready in the very operation where it occurs. Erase sequencing faults show within one operation: lock bits or EEPROM cleared too early, or cleared despite the save fuse. A lock value sampled mid-sweep exposes the first, and the EEPROM readback of a second instance with the save fuse programmed exposes the second.

// File: rtl/pprog_pkg.sv
package pprog_pkg;
  localparam logic [7:0] CMD_CHIP_ERASE  = 8'h80;
  localparam logic [7:0] CMD_PAGE_WRITE  = 8'h10;

  typedef enum logic [1:0] {
    MODE_ADDR = 2'b00,
    MODE_DATA = 2'b01,
    MODE_CMD  = 2'b10,
    MODE_NOP  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/pp_edge_sync.sv
module pp_edge_sync #(
  parameter int          W    = 3,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= IDLE[i];
        s2 <= IDLE[i];
        s3 <= IDLE[i];
      end else begin
        s1 <= async_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
    assign fall[i] = ~s2 & s3;
  end
endmodule

// File: rtl/pp_cmd_loader.sv
module pp_cmd_loader
  import pprog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_WORDS = 16,
  localparam int OFS_W     = $clog2(PAGE_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busy,
  input  logic                         load_rise,
  input  logic                         latch_rise,
  input  logic [1:0]                   mode,
  input  logic                         byte_sel,
  input  logic [7:0]                   din,
  output logic [7:0]                   cmd_q,
  output logic [ADDR_W-1:0]            addr_q,
  output logic [PAGE_WORDS-1:0][15:0]  page_buf
);
  logic [7:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      addr_q   <= '0;
      lo_q     <= 8'hFF;
      hi_q     <= 8'hFF;
      page_buf <= '1;
    end else if (!busy) begin
      if (load_rise) begin
        case (mode_e'(mode))
          MODE_CMD:  cmd_q <= din;
          MODE_ADDR: if (!byte_sel) addr_q <= din[ADDR_W-1:0];
          MODE_DATA: if (byte_sel) hi_q <= din; else lo_q <= din;
          default: ;
        endcase
      end
      if (latch_rise) page_buf[addr_q[OFS_W-1:0]] <= {hi_q, lo_q};
    end
  end

  assert_hold_when_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cmd_q) && $stable(addr_q) && $stable(page_buf)));

  assert_addr_high_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (load_rise && mode == MODE_ADDR && byte_sel) |=> $stable(addr_q));
endmodule

// File: rtl/pp_flash_ram.sv
module pp_flash_ram #(
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_prog_engine.sv
module pp_prog_engine
  import pprog_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          PAGE_WORDS  = 16,
  parameter int          BUSY_CYCLES = 300,   // must be >= 2**ADDR_W
  parameter int          EE_DEPTH    = 16,
  parameter int          LOCK_W      = 2,
  parameter logic [LOCK_W-1:0] LOCK_INIT = '0,
  parameter logic [7:0]  FUSE_INIT   = 8'hFF,
  parameter int          EESAVE_BIT  = 3,
  localparam int OFS_W = $clog2(PAGE_WORDS),
  localparam int EE_AW = $clog2(EE_DEPTH),
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1),
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_fall,
  input  logic [7:0]                  cmd,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [PAGE_WORDS-1:0][15:0] page_buf,
  input  logic [EE_AW-1:0]            ee_raddr,
  output logic                        busy_q,
  output logic                        fl_we,
  output logic [ADDR_W-1:0]           fl_waddr,
  output logic [15:0]                 fl_wdata,
  output logic [7:0]                  ee_rdata,
  output logic [LOCK_W-1:0]           lock_q,
  output logic [7:0]                  fuse_q
);
  op_e             op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]      ee_q [EE_DEPTH];
  logic            start, last;
  logic [OFS_W-1:0] ofs;

  assign start = wr_fall && !busy_q &&
                 (cmd == CMD_CHIP_ERASE || cmd == CMD_PAGE_WRITE);
  assign last  = (cnt_q == CNT_W'(BUSY_CYCLES - 1));
  assign ofs   = cnt_q[OFS_W-1:0];

  always_comb begin
    fl_we    = 1'b0;
    fl_waddr = cnt_q[ADDR_W-1:0];
    fl_wdata = 16'hFFFF;
    if (busy_q && op_q == OP_ERASE) begin
      fl_we = (32'(cnt_q) < DEPTH);
    end else if (busy_q && op_q == OP_WRITE) begin
      fl_we    = (32'(cnt_q) < PAGE_WORDS);
      fl_waddr = {addr[ADDR_W-1:OFS_W], ofs};
      fl_wdata = page_buf[ofs];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
      lock_q <= LOCK_INIT;
      fuse_q <= FUSE_INIT;
      for (int i = 0; i < EE_DEPTH; i++) ee_q[i] <= 8'(i) ^ 8'hA5;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      op_q   <= (cmd == CMD_CHIP_ERASE) ? OP_ERASE : OP_WRITE;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        op_q   <= OP_IDLE;
        if (op_q == OP_ERASE) begin
          lock_q <= '1;
          if (fuse_q[EESAVE_BIT])
            for (int i = 0; i < EE_DEPTH; i++) ee_q[i] <= 8'hFF;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) ee_rdata <= ee_q[ee_raddr];

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> busy_q);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && last) |=> !busy_q);

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (32'(cnt_q) < BUSY_CYCLES));

  assert_lock_at_end_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_q) |-> ($past(busy_q) && !busy_q));

  assert_fuse_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && op_q == OP_ERASE) |=> $stable(fuse_q));
endmodule

// File: rtl/pprog_target.sv
module pprog_target
  import pprog_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          PAGE_WORDS  = 16,
  parameter int          BUSY_CYCLES = 300,
  parameter int          EE_DEPTH    = 16,
  parameter int          LOCK_W      = 2,
  parameter logic [LOCK_W-1:0] LOCK_INIT = '0,
  parameter logic [7:0]  FUSE_INIT   = 8'hFF,
  parameter int          EESAVE_BIT  = 3,
  localparam int EE_AW = $clog2(EE_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              byte_sel,
  input  logic [7:0]        data_in,
  input  logic              load_stb,
  input  logic              latch_stb,
  input  logic              wr_n,
  output logic              ready,
  input  logic [ADDR_W-1:0] flash_raddr,
  output logic [15:0]       flash_rdata,
  input  logic [EE_AW-1:0]  ee_raddr,
  output logic [7:0]        ee_rdata,
  output logic [LOCK_W-1:0] lock_bits,
  output logic [7:0]        fuse_bits
);
  logic [2:0]                  rise, fall;
  logic                        busy;
  logic [7:0]                  cmd;
  logic [ADDR_W-1:0]           addr;
  logic [PAGE_WORDS-1:0][15:0] page_buf;
  logic                        fl_we;
  logic [ADDR_W-1:0]           fl_waddr;
  logic [15:0]                 fl_wdata;

  pp_edge_sync #(.W(3), .IDLE(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({wr_n, latch_stb, load_stb}),
    .rise(rise), .fall(fall)
  );

  pp_cmd_loader #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_loader (
    .clk(clk), .rst(rst), .busy(busy),
    .load_rise(rise[0]), .latch_rise(rise[1]),
    .mode(mode_sel), .byte_sel(byte_sel), .din(data_in),
    .cmd_q(cmd), .addr_q(addr), .page_buf(page_buf)
  );

  pp_prog_engine #(
    .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .BUSY_CYCLES(BUSY_CYCLES),
    .EE_DEPTH(EE_DEPTH), .LOCK_W(LOCK_W), .LOCK_INIT(LOCK_INIT),
    .FUSE_INIT(FUSE_INIT), .EESAVE_BIT(EESAVE_BIT)
  ) u_engine (
    .clk(clk), .rst(rst), .wr_fall(fall[2]),
    .cmd(cmd), .addr(addr), .page_buf(page_buf), .ee_raddr(ee_raddr),
    .busy_q(busy), .fl_we(fl_we), .fl_waddr(fl_waddr), .fl_wdata(fl_wdata),
    .ee_rdata(ee_rdata), .lock_q(lock_bits), .fuse_q(fuse_bits)
  );

  pp_flash_ram #(.AW(ADDR_W), .DW(16)) u_flash (
    .clk(clk), .we(fl_we), .waddr(fl_waddr), .wdata(fl_wdata),
    .raddr(flash_raddr), .rdata(flash_rdata)
  );

  assign ready = ~busy;

  assert_no_write_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fl_we);

  // R6: page writes stay within the page selected by the held address
  assert_write_in_page_R6: assert property (@(posedge clk) disable iff (rst)
    (fl_we && cmd == CMD_PAGE_WRITE) |->
      (fl_waddr[ADDR_W-1:$clog2(PAGE_WORDS)] == addr[ADDR_W-1:$clog2(PAGE_WORDS)]));
endmodule

// File: tb/pprog_target_tb.sv
module pprog_target_tb;
  localparam int AW = 6, PW = 8, OW = 3, BUSY = 100, EED = 8, LW = 2, EEB = 3;
  localparam logic [LW-1:0] LOCK0 = 2'b00;
  localparam logic [7:0] FUSE_A = 8'hFF, FUSE_B = 8'hF7;

  logic clk = 0, rst = 1;
  logic [1:0] mode_sel = 2'b11;
  logic byte_sel = 0, load_stb = 0, latch_stb = 0, wr_n = 1;
  logic [7:0] data_in = 0;
  logic [AW-1:0] flash_raddr = 0;
  logic [2:0] ee_raddr = 0;
  logic ready, ready2;
  logic [15:0] fl_rd, fl_rd2;
  logic [7:0] ee_rd, ee_rd2, fuse, fuse2;
  logic [LW-1:0] lock, lock2;
  int nchk = 0, nerr = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pprog_target #(.ADDR_W(AW), .PAGE_WORDS(PW), .BUSY_CYCLES(BUSY), .EE_DEPTH(EED),
    .LOCK_W(LW), .LOCK_INIT(LOCK0), .FUSE_INIT(FUSE_A), .EESAVE_BIT(EEB)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .byte_sel(byte_sel), .data_in(data_in),
    .load_stb(load_stb), .latch_stb(latch_stb), .wr_n(wr_n), .ready(ready),
    .flash_raddr(flash_raddr), .flash_rdata(fl_rd), .ee_raddr(ee_raddr), .ee_rdata(ee_rd),
    .lock_bits(lock), .fuse_bits(fuse));

  pprog_target #(.ADDR_W(AW), .PAGE_WORDS(PW), .BUSY_CYCLES(BUSY), .EE_DEPTH(EED),
    .LOCK_W(LW), .LOCK_INIT(LOCK0), .FUSE_INIT(FUSE_B), .EESAVE_BIT(EEB)) u_dut_save (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .byte_sel(byte_sel), .data_in(data_in),
    .load_stb(load_stb), .latch_stb(latch_stb), .wr_n(wr_n), .ready(ready2),
    .flash_raddr(flash_raddr), .flash_rdata(fl_rd2), .ee_raddr(ee_raddr), .ee_rdata(ee_rd2),
    .lock_bits(lock2), .fuse_bits(fuse2));

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0305) ^ 16'h5A00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_load(input logic [1:0] m, input logic bs, input logic [7:0] v);
    @(negedge clk); mode_sel = m; byte_sel = bs; data_in = v;
    repeat (2) @(negedge clk); load_stb = 1;
    repeat (4) @(negedge clk); load_stb = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_latch();
    @(negedge clk); byte_sel = 1;
    repeat (2) @(negedge clk); latch_stb = 1;
    repeat (4) @(negedge clk); latch_stb = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_wr();
    @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk); wr_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_word(input int a, input logic [15:0] w, input logic extra_hi_addr);
    pulse_load(2'b00, 0, 8'(a));
    if (extra_hi_addr) pulse_load(2'b00, 1, 8'h3F);
    pulse_load(2'b01, 0, w[7:0]);
    pulse_load(2'b01, 1, w[15:8]);
    pulse_latch();
  endtask

  task automatic rd_flash(input int a, output logic [15:0] d);
    @(negedge clk); flash_raddr = AW'(a);
    @(negedge clk); d = fl_rd;
  endtask

  // kind 0: plain, 1: check lock mid-sweep, 2: stray strobes while busy
  task automatic run_op(input int kind);
    int lat, t0, dur;
    lat = 0;
    @(negedge clk); wr_n = 0;
    while (ready && lat < 10) begin @(negedge clk); lat++; end
    chk("R7 start latency", lat, 3);
    t0 = cyc;
    repeat (4) @(negedge clk); wr_n = 1;
    if (kind == 1) begin
      repeat (20) @(negedge clk);
      chk("R10 lock held mid erase", lock, LOCK0);
      chk("R10 lock held mid erase save", lock2, LOCK0);
    end else if (kind == 2) begin
      pulse_load(2'b00, 0, 8'h00);
      pulse_load(2'b01, 0, 8'hAD);
      pulse_load(2'b01, 1, 8'hDE);
      pulse_latch();
      pulse_load(2'b10, 0, 8'h80);
      pulse_wr();
    end
    while (!ready) @(negedge clk);
    dur = cyc - t0;
    chk("R7 busy length", dur, BUSY);
    chk("R7 both instances idle", ready2, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int bad, bad2;
    repeat (3) @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 1);
    chk("R1 lock", lock, LOCK0);
    chk("R1 fuse", fuse, FUSE_A);
    chk("R1 fuse save", fuse2, FUSE_B);
    bad = 0;
    for (int i = 0; i < EED; i++) begin
      @(negedge clk); ee_raddr = 3'(i);
      @(negedge clk); if (ee_rd !== (8'(i) ^ 8'hA5) || ee_rd2 !== (8'(i) ^ 8'hA5)) bad++;
    end
    chk("R1 R12 eeprom reset pattern", bad, 0);

    // first chip erase, R2 command decode, R8 R9 R10
    pulse_load(2'b10, 0, 8'h80);
    run_op(1);
    bad = 0;
    for (int a = 0; a < (1 << AW); a++) begin rd_flash(a, d); if (d !== 16'hFFFF) bad++; end
    chk("R8 flash erased", bad, 0);
    chk("R8 lock set to ones", lock, 2'b11);
    chk("R8 fuse unchanged", fuse, FUSE_A);
    chk("R8 fuse unchanged save", fuse2, FUSE_B);
    bad = 0; bad2 = 0;
    for (int i = 0; i < EED; i++) begin
      @(negedge clk); ee_raddr = 3'(i);
      @(negedge clk);
      if (ee_rd !== 8'hFF) bad++;
      if (ee_rd2 !== (8'(i) ^ 8'hA5)) bad2++;
    end
    chk("R9 eeprom erased when save fuse clear", bad, 0);
    chk("R9 eeprom kept when save fuse programmed", bad2, 0);

    // program every page; R3 R4 R5 R6
    for (int p = 0; p < (1 << (AW - OW)); p++) begin
      pulse_load(2'b10, 0, 8'h10);
      for (int w = 0; w < PW; w++) load_word(p * PW + w, pat(p * PW + w), p == 3);
      run_op(0);
    end
    bad = 0;
    for (int a = 0; a < (1 << AW); a++) begin rd_flash(a, d); if (d !== pat(a)) bad++; end
    chk("R3 R4 R5 R6 programmed image", bad, 0);

    // R11: strays during a page write are ignored
    run_op(2);
    rd_flash(0, d);
    chk("R11 stray address and latch ignored", d, pat(0));
    run_op(0);
    bad = 0;
    for (int a = 56; a < 64; a++) begin rd_flash(a, d); if (d !== pat(a)) bad++; end
    chk("R11 page buffer and command kept", bad, 0);
    rd_flash(0, d);
    chk("R11 other page untouched", d, pat(0));

    // R2 unknown command
    pulse_load(2'b10, 0, 8'h20);
    @(negedge clk); wr_n = 0;
    bad = 0;
    for (int k = 0; k < 15; k++) begin @(negedge clk); if (!ready) bad++; end
    wr_n = 1;
    repeat (4) @(negedge clk);
    chk("R2 unknown command keeps ready", bad, 0);
    rd_flash(5, d);
    chk("R2 unknown command leaves flash", d, pat(5));

    // second erase over programmed data
    pulse_load(2'b10, 0, 8'h80);
    run_op(0);
    bad = 0;
    for (int a = 0; a < (1 << AW); a++) begin rd_flash(a, d); if (d !== 16'hFFFF) bad++; end
    chk("R8 programmed flash erased", bad, 0);
    chk("R8 lock ones save instance", lock2, 2'b11);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule